// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, made of a segment number and an offset, into a flat physical address. A table-origin register gives the memory address of a table of segment descriptors. A table-size register gives the number of segments in that table. For each request the block first checks the segment number against the table size. It then reads the segment's two-word descriptor through a synchronous memory read port. Finally it checks the offset against the segment's length and the access type against the segment's write protection. It returns either the physical address or a fault code.

A request is accepted with a valid/ready handshake. The block holds one request at a time, and `req_ready` stays low until that request's response has been given. The response is a single-cycle pulse carrying the physical address, a fault flag and a fault cause.

The controller is a five-state machine:
- IDLE: ready for a request. On acceptance it takes transition RANGE_FAIL to RESPOND, or transition START_FETCH to FETCH_BASE.
- FETCH_BASE: reads descriptor word 0, then moves on (FETCH_NEXT).
- FETCH_LEN: captures the base and reads descriptor word 1 (LAST_WORD).
- JUDGE: evaluates word 1 and registers the result (DECIDE).
- RESPOND: presents the response for one cycle, then returns to IDLE (COMPLETE).

Top module: `segxl_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: For an in-range segment s, exactly two memory reads are issued. The first is at `tbl_base + 2*s` and the second at `tbl_base + 2*s + 1`. Word 0 holds the segment base in its low ADDR_W bits. Word 1 holds bit 31 = valid, bit 30 = read-only, and bits 29:0 = length.
- R3: A segment number greater than or equal to `tbl_len` returns fault cause 1. No memory read is issued, and the response appears in the cycle right after acceptance.
- R4: A descriptor whose valid bit (word 1 bit 31) is 0 returns fault cause 2.
- R5: An offset greater than or equal to the descriptor length (word 1 bits 29:0) returns fault cause 3.
- R6: A write (`req_write`=1) to a segment whose read-only bit (word 1 bit 30) is 1 returns fault cause 4. A read of the same segment succeeds.
- R7: A request that passes every check returns `rsp_fault`=0, cause 0 and `rsp_paddr` = base + offset.
- R8: Once a request is accepted, `req_ready` stays 0 until the response cycle has ended. Each request yields exactly one single-cycle `rsp_valid` pulse. For an in-range segment the pulse comes four cycles after acceptance.
- R9: When several checks fail, the reported cause follows the order range (1) over invalid (2) over length (3) over protection (4).
- R10: On any fault, `rsp_paddr` is 0 and `rsp_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | ADDR_W | Memory address of the descriptor table |
| tbl_len | input | SEG_W+1 | Number of segments in the table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_rd_addr | output | ADDR_W | Descriptor word address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 3 | 0 none, 1 range, 2 invalid, 3 length, 4 protection |
| rsp_paddr | output | ADDR_W | Physical address, 0 on fault |

## Verification
The bench builds the block with SEG_W=3, OFF_W=12, ADDR_W=16 and DATA_W=32. This makes a table of eight descriptors that fits in a 64-word memory model. With these values, `tbl_len` can reach its full value of 8, and also 5 and 0, so both edges of the range check are reached. Offsets up to 4095 let every length edge be hit exactly. The table holds segments with mixed flag combinations, so the fault priority order can be driven through several of its pairs.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_RANGE = 3'd1,
        CAUSE_INVAL = 3'd2,
        CAUSE_LIMIT = 3'd3,
        CAUSE_PROT  = 3'd4
    } cause_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_BASE,
        S_FETCH_LEN,
        S_JUDGE,
        S_RESPOND
    } state_t;

endpackage

// File: rtl/segxl_judge.sv
module segxl_judge
    import segxl_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [DATA_W-1:0] desc_word1,
    input  logic [OFF_W-1:0]  off,
    input  logic              wr,
    output cause_t            cause,
    output logic [ADDR_W-1:0] paddr
);

    localparam int LEN_W   = DATA_W - 2;
    localparam int VAL_BIT = DATA_W - 1;
    localparam int RO_BIT  = DATA_W - 2;

    logic [LEN_W-1:0] seg_len;
    logic [LEN_W-1:0] off_ext;
    logic             seg_valid;
    logic             seg_ro;

    always_comb begin
        seg_len   = desc_word1[LEN_W-1:0];
        seg_valid = desc_word1[VAL_BIT];
        seg_ro    = desc_word1[RO_BIT];
        off_ext   = LEN_W'(off);
        paddr     = seg_base + ADDR_W'(off);
        if (!seg_valid) begin
            cause = CAUSE_INVAL;
        end else if (off_ext >= seg_len) begin
            cause = CAUSE_LIMIT;
        end else if (wr && seg_ro) begin
            cause = CAUSE_PROT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/segxl_ctrl.sv
module segxl_ctrl
    import segxl_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [ADDR_W-1:0] base_word,
    output logic [ADDR_W-1:0] chk_base,
    output logic [OFF_W-1:0]  chk_off,
    output logic              chk_wr,
    input  cause_t            chk_cause,
    input  logic [ADDR_W-1:0] chk_paddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_cause,
    output logic [ADDR_W-1:0] rsp_paddr
);

    state_t            state_q, state_d;
    logic              accept;
    logic              seg_oob;
    logic [ADDR_W-1:0] desc_ptr_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  off_q;
    logic              wr_q;
    cause_t            cause_q;
    logic [ADDR_W-1:0] paddr_q;

    assign accept  = req_valid && (state_q == S_IDLE);
    assign seg_oob = ({1'b0, req_seg} >= tbl_len);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (accept) state_d = seg_oob ? S_RESPOND : S_FETCH_BASE;
            S_FETCH_BASE: state_d = S_FETCH_LEN;
            S_FETCH_LEN:  state_d = S_JUDGE;
            S_JUDGE:      state_d = S_RESPOND;
            S_RESPOND:    state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            desc_ptr_q <= '0;
            base_q     <= '0;
            off_q      <= '0;
            wr_q       <= 1'b0;
            cause_q    <= CAUSE_NONE;
            paddr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                off_q      <= req_off;
                wr_q       <= req_write;
                desc_ptr_q <= tbl_base + ADDR_W'({req_seg, 1'b0});
                if (seg_oob) begin
                    cause_q <= CAUSE_RANGE;
                    paddr_q <= '0;
                end
            end
            if (state_q == S_FETCH_LEN) begin
                base_q <= base_word;
            end
            if (state_q == S_JUDGE) begin
                cause_q <= chk_cause;
                paddr_q <= (chk_cause == CAUSE_NONE) ? chk_paddr : '0;
            end
        end
    end

    always_comb begin
        req_ready   = (state_q == S_IDLE);
        mem_rd_en   = (state_q == S_FETCH_BASE) || (state_q == S_FETCH_LEN);
        mem_rd_addr = (state_q == S_FETCH_LEN) ? desc_ptr_q + ADDR_W'(1) : desc_ptr_q;
        rsp_valid   = (state_q == S_RESPOND);
        rsp_fault   = (cause_q != CAUSE_NONE);
        rsp_cause   = cause_q;
        rsp_paddr   = paddr_q;
        chk_base    = base_q;
        chk_off     = off_q;
        chk_wr      = wr_q;
    end

    // R3: an out-of-range segment goes straight to the response, with no read
    p_no_read_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seg_oob) |=> (rsp_valid && !mem_rd_en && rsp_cause == 3'd1));

    // R2: the second descriptor word sits one address above the first
    p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_LEN) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1)));

    // R8: the block never looks ready while a fetch is outstanding
    p_busy_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R8: the response is a single-cycle pulse
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/segxl_unit.sv
module segxl_unit
    import segxl_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_cause,
    output logic [ADDR_W-1:0] rsp_paddr
);

    logic [ADDR_W-1:0] chk_base;
    logic [OFF_W-1:0]  chk_off;
    logic              chk_wr;
    cause_t            chk_cause;
    logic [ADDR_W-1:0] chk_paddr;

    segxl_ctrl #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_base   (tbl_base),
        .tbl_len    (tbl_len),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_seg    (req_seg),
        .req_off    (req_off),
        .req_write  (req_write),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_addr(mem_rd_addr),
        .base_word  (mem_rd_data[ADDR_W-1:0]),
        .chk_base   (chk_base),
        .chk_off    (chk_off),
        .chk_wr     (chk_wr),
        .chk_cause  (chk_cause),
        .chk_paddr  (chk_paddr),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_cause  (rsp_cause),
        .rsp_paddr  (rsp_paddr)
    );

    segxl_judge #(
        .OFF_W (OFF_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_judge (
        .seg_base  (chk_base),
        .desc_word1(mem_rd_data),
        .off       (chk_off),
        .wr        (chk_wr),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    // R10: a refused translation never exposes an address
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R7: the fault flag agrees with the cause code
    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

endmodule

// File: tb/tb_segxl_unit.sv
module tb_segxl_unit;

    localparam int SEG_W  = 3;
    localparam int OFF_W  = 12;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TBASE  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] tbl_base = ADDR_W'(TBASE);
    logic [SEG_W:0]    tbl_len = 4'd8;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic              req_write = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;
    logic              rsp_valid;
    logic              rsp_fault;
    logic [2:0]        rsp_cause;
    logic [ADDR_W-1:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] mem [64];
    int                rd_cnt;
    int                rd_addr0, rd_addr1;

    always #5 clk = ~clk;

    segxl_unit #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_write(req_write), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[5:0]];
            if (rd_cnt == 0) rd_addr0 = int'(mem_rd_addr);
            if (rd_cnt == 1) rd_addr1 = int'(mem_rd_addr);
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] w1(input bit v, input bit ro, input int len);
        return {v, ro, 30'(len)};
    endfunction

    task automatic put_seg(input int s, input int base, input int len, input bit v, input bit ro);
        mem[TBASE + 2*s]     = DATA_W'(base);
        mem[TBASE + 2*s + 1] = w1(v, ro, len);
    endtask

    task automatic do_req(input int seg, input int off, input bit wr,
                          input int exp_cause, input int exp_paddr, input string tag);
        int lat;
        int exp_lat;
        bit busy_ok;
        exp_lat = (exp_cause == 1) ? 1 : 4;
        @(negedge clk);
        req_seg   = SEG_W'(seg);
        req_off   = OFF_W'(off);
        req_write = wr;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        rd_cnt = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!rsp_valid && lat < 20) begin
            if (req_ready) busy_ok = 1'b0;
            lat++;
            @(negedge clk);
        end
        if (req_ready) busy_ok = 1'b0;
        chk(busy_ok, {tag, " R8 ready low while busy"}, 1, 0);
        chk(lat == exp_lat, {tag, " R8 latency"}, lat, exp_lat);
        chk(int'(rsp_cause) == exp_cause, {tag, " cause"}, int'(rsp_cause), exp_cause);
        chk(int'(rsp_paddr) == exp_paddr, {tag, " paddr (R7/R10)"}, int'(rsp_paddr), exp_paddr);
        chk(rsp_fault == (exp_cause != 0), {tag, " R10 fault flag"}, int'(rsp_fault), int'(exp_cause != 0));
        if (exp_cause == 1) begin
            chk(rd_cnt == 0, {tag, " R3 no memory read"}, rd_cnt, 0);
        end else begin
            chk(rd_cnt == 2, {tag, " R2 read count"}, rd_cnt, 2);
            chk(rd_addr0 == TBASE + 2*seg, {tag, " R2 word0 addr"}, rd_addr0, TBASE + 2*seg);
            chk(rd_addr1 == TBASE + 2*seg + 1, {tag, " R2 word1 addr"}, rd_addr1, TBASE + 2*seg + 1);
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R8 single pulse, ready again"}, int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(mem_rd_en == 1'b0, "R1 mem_rd_en", int'(mem_rd_en), 0);
    endtask

    task automatic t_success();
        do_req(3, 400, 1'b0, 0, 1727, "R7 seg3");
        do_req(0, 430, 1'b1, 0, 649, "R7 seg0 write");
        do_req(2, 99, 1'b0, 0, 189, "R7 seg2 last byte");
    endtask

    task automatic t_limit();
        do_req(2, 500, 1'b0, 3, 0, "R5 seg2 off500");
        do_req(2, 100, 1'b0, 3, 0, "R5 seg2 off=len");
        do_req(4, 112, 1'b0, 3, 0, "R5 seg4");
    endtask

    task automatic t_range();
        tbl_len = 4'd5;
        do_req(5, 0, 1'b0, 1, 0, "R3 seg=len");
        do_req(4, 95, 1'b0, 0, 2047, "R3 seg=len-1 ok");
        tbl_len = 4'd0;
        do_req(0, 0, 1'b0, 1, 0, "R3 empty table");
        tbl_len = 4'd8;
        do_req(7, 0, 1'b1, 2, 0, "R3 full table seg7 reaches desc");
    endtask

    task automatic t_valid();
        do_req(5, 0, 1'b0, 2, 0, "R4 invalid desc");
    endtask

    task automatic t_prot();
        do_req(1, 10, 1'b1, 4, 0, "R6 write ro");
        do_req(1, 10, 1'b0, 0, 2310, "R6 read ro");
    endtask

    task automatic t_prio();
        do_req(6, 20, 1'b1, 3, 0, "R9 limit over prot");
        do_req(7, 5, 1'b1, 2, 0, "R9 invalid over limit");
        tbl_len = 4'd6;
        do_req(7, 5, 1'b1, 1, 0, "R9 range over invalid");
        tbl_len = 4'd8;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        rd_cnt = 0;
        rd_addr0 = 0;
        rd_addr1 = 0;
        put_seg(0, 219, 600, 1'b1, 1'b0);
        put_seg(1, 2300, 14, 1'b1, 1'b1);
        put_seg(2, 90, 100, 1'b1, 1'b0);
        put_seg(3, 1327, 580, 1'b1, 1'b0);
        put_seg(4, 1952, 96, 1'b1, 1'b0);
        put_seg(5, 500, 50, 1'b0, 1'b0);
        put_seg(6, 3000, 10, 1'b1, 1'b1);
        put_seg(7, 700, 0, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_success();
        t_limit();
        t_range();
        t_valid();
        t_prot();
        t_prio();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule